// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Selector

This block picks the source of the two ALU operands in the execute stage of a five-stage in-order pipeline. For each operand it compares the operand's source register index, held in the ID/EX pipeline register, with the destination indices of the two older instructions ahead of it: the one in EX/MEM and the one in MEM/WB. It then selects one of three values: the value read from the register file, the ALU result waiting in EX/MEM, or the value being written back from MEM/WB. When both older instructions target the operand's register, the result in EX/MEM is taken, because it belongs to the younger of the two. Register 0 is hard-wired to zero and is never a forwarding target. An instruction that writes no register presents a cleared write enable, and this prevents any match.

The block also holds the register file used by the decode stage. The MEM/WB write port writes this register file on the clock edge. Its two decode read ports are write-through: a read of the register that MEM/WB is writing in the same cycle returns the new value, not the stored one. The selects leave the block so that the pipeline can observe them. The chosen operands go straight to the ALU, which lies outside this block, as does the data memory.

Top module: `opnd_route`

## Requirements
- R1: When the EX/MEM write enable is 1, its destination is nonzero, and its destination equals an operand's source index, that operand's select is 2'b10 and the operand equals the EX/MEM value.
- R2: When the MEM/WB write enable is 1, its destination is nonzero, it equals an operand's source index, and R1 does not apply to that operand, the select is 2'b01 and the operand equals the MEM/WB value.
- R3: When both EX/MEM and MEM/WB qualify for the same operand, EX/MEM wins: select 2'b10 and the EX/MEM value.
- R4: When neither stage qualifies, the select is 2'b00 and the operand equals the register-file value supplied with the ID/EX source.
- R5: A source index of 0 is never forwarded, even when a stage has write enable 1 and destination 0. The select is 2'b00.
- R6: A stage whose write enable is 0 never forwards, even when its destination equals the source index.
- R7: Operands A and B are resolved independently. In the same cycle, each may take a different source.
- R8: A decode read of a nonzero register that MEM/WB writes in the same cycle returns the MEM/WB value.
- R9: The register file reads all zeros after reset. A MEM/WB write to a nonzero register is stored at the clock edge and returned by later reads. Register 0 always reads 0, and writes to it have no effect.
- R10: The select code 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears the register file |
| id_rs_a | input | 5 | Decode read index, port A |
| id_rs_b | input | 5 | Decode read index, port B |
| id_val_a | output | 32 | Decode read data A, write-through |
| id_val_b | output | 32 | Decode read data B, write-through |
| ex_src_a | input | 5 | ID/EX source index of operand A |
| ex_src_b | input | 5 | ID/EX source index of operand B |
| ex_rf_a | input | 32 | Register-file value latched with operand A |
| ex_rf_b | input | 32 | Register-file value latched with operand B |
| exm_we | input | 1 | EX/MEM writes a register |
| exm_rd | input | 5 | EX/MEM destination index |
| exm_val | input | 32 | EX/MEM ALU result |
| mwb_we | input | 1 | MEM/WB writes a register |
| mwb_rd | input | 5 | MEM/WB destination index |
| mwb_val | input | 32 | MEM/WB write-back value |
| sel_a | output | 2 | Operand A source: 00 register file, 10 EX/MEM, 01 MEM/WB |
| sel_b | output | 2 | Operand B source, same code |
| opnd_a | output | 32 | Selected operand A |
| opnd_b | output | 32 | Selected operand B |

## Verification
The bench builds the block with its default parameters: 32-bit data and 5-bit register indices, which gives 32 registers. With these values the directed cases reach the top register, 31, for a same-cycle write and read, and register 0 for the hard-wired-zero cases. In the random phase the indices are drawn from the low four registers. This makes single matches, dual matches and register-0 collisions frequent under the full-width comparators. Meanwhile, write-back traffic keeps filling the register file, so the stored contents are compared against a bench model of them.

// File: rtl/opnd_route_pkg.sv
package opnd_route_pkg;

    localparam int DATA_W_DEF = 32;
    localparam int IDX_W_DEF  = 5;

    typedef enum logic [1:0] {
        SRC_RF  = 2'b00,
        SRC_MWB = 2'b01,
        SRC_EXM = 2'b10
    } src_sel_e;

    // younger producer first, then older, then the register file
    function automatic src_sel_e pick_src(input logic exm_hit, input logic mwb_hit);
        if (exm_hit)      return SRC_EXM;
        else if (mwb_hit) return SRC_MWB;
        else              return SRC_RF;
    endfunction

endpackage

// File: rtl/fwd_pick.sv
module fwd_pick
    import opnd_route_pkg::*;
#(
    parameter int DW = DATA_W_DEF,
    parameter int AW = IDX_W_DEF
) (
    input  logic [AW-1:0] src,
    input  logic [DW-1:0] rf_val,
    input  logic          exm_we,
    input  logic [AW-1:0] exm_rd,
    input  logic [DW-1:0] exm_val,
    input  logic          mwb_we,
    input  logic [AW-1:0] mwb_rd,
    input  logic [DW-1:0] mwb_val,
    output src_sel_e      sel,
    output logic [DW-1:0] val
);

    localparam logic [AW-1:0] ZERO_IDX = '0;

    logic exm_hit;
    logic mwb_hit;

    always_comb begin
        exm_hit = exm_we && (exm_rd != ZERO_IDX) && (exm_rd == src);
        mwb_hit = mwb_we && (mwb_rd != ZERO_IDX) && (mwb_rd == src);
        sel     = pick_src(exm_hit, mwb_hit);
        unique case (sel)
            SRC_EXM: val = exm_val;
            SRC_MWB: val = mwb_val;
            default: val = rf_val;
        endcase
    end

endmodule

// File: rtl/regfile_wt.sv
module regfile_wt #(
    parameter int DW  = 32,
    parameter int AW  = 5,
    parameter int NRD = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic [AW-1:0] ra [NRD],
    output logic [DW-1:0] rd [NRD]
);

    localparam int NREG = 1 << AW;
    localparam logic [AW-1:0] ZERO_IDX = '0;

    logic [DW-1:0] mem [NREG];
    logic          wr_live;

    assign wr_live = we && (wa != ZERO_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (wr_live) begin
            mem[wa] <= wd;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rport
        always_comb begin
            if (ra[p] == ZERO_IDX)                rd[p] = '0;
            else if (wr_live && (wa == ra[p]))    rd[p] = wd;
            else                                  rd[p] = mem[ra[p]];
        end
    end

endmodule

// File: rtl/opnd_route.sv
module opnd_route
    import opnd_route_pkg::*;
#(
    parameter int DW = DATA_W_DEF,
    parameter int AW = IDX_W_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] id_rs_a,
    input  logic [AW-1:0] id_rs_b,
    output logic [DW-1:0] id_val_a,
    output logic [DW-1:0] id_val_b,
    input  logic [AW-1:0] ex_src_a,
    input  logic [AW-1:0] ex_src_b,
    input  logic [DW-1:0] ex_rf_a,
    input  logic [DW-1:0] ex_rf_b,
    input  logic          exm_we,
    input  logic [AW-1:0] exm_rd,
    input  logic [DW-1:0] exm_val,
    input  logic          mwb_we,
    input  logic [AW-1:0] mwb_rd,
    input  logic [DW-1:0] mwb_val,
    output logic [1:0]    sel_a,
    output logic [1:0]    sel_b,
    output logic [DW-1:0] opnd_a,
    output logic [DW-1:0] opnd_b
);

    localparam int NOP = 2;

    logic [AW-1:0] src_v [NOP];
    logic [DW-1:0] rf_v  [NOP];
    src_sel_e      sel_v [NOP];
    logic [DW-1:0] op_v  [NOP];
    logic [AW-1:0] id_ra [NOP];
    logic [DW-1:0] id_rd [NOP];

    assign src_v[0] = ex_src_a;
    assign src_v[1] = ex_src_b;
    assign rf_v[0]  = ex_rf_a;
    assign rf_v[1]  = ex_rf_b;
    assign id_ra[0] = id_rs_a;
    assign id_ra[1] = id_rs_b;

    for (genvar k = 0; k < NOP; k++) begin : g_opnd
        fwd_pick #(.DW(DW), .AW(AW)) u_pick (
            .src     (src_v[k]),
            .rf_val  (rf_v[k]),
            .exm_we  (exm_we),
            .exm_rd  (exm_rd),
            .exm_val (exm_val),
            .mwb_we  (mwb_we),
            .mwb_rd  (mwb_rd),
            .mwb_val (mwb_val),
            .sel     (sel_v[k]),
            .val     (op_v[k])
        );
    end

    regfile_wt #(.DW(DW), .AW(AW), .NRD(NOP)) u_rf (
        .clk (clk),
        .rst (rst),
        .we  (mwb_we),
        .wa  (mwb_rd),
        .wd  (mwb_val),
        .ra  (id_ra),
        .rd  (id_rd)
    );

    assign sel_a    = sel_v[0];
    assign sel_b    = sel_v[1];
    assign opnd_a   = op_v[0];
    assign opnd_b   = op_v[1];
    assign id_val_a = id_rd[0];
    assign id_val_b = id_rd[1];

endmodule

// File: rtl/opnd_route_chk.sv
module opnd_route_chk #(
    parameter int DW = 32,
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] id_rs_a,
    input logic [DW-1:0] id_val_a,
    input logic [AW-1:0] ex_src_a,
    input logic [AW-1:0] ex_src_b,
    input logic [DW-1:0] ex_rf_a,
    input logic [DW-1:0] ex_rf_b,
    input logic          exm_we,
    input logic [AW-1:0] exm_rd,
    input logic [DW-1:0] exm_val,
    input logic          mwb_we,
    input logic [AW-1:0] mwb_rd,
    input logic [DW-1:0] mwb_val,
    input logic [1:0]    sel_a,
    input logic [1:0]    sel_b,
    input logic [DW-1:0] opnd_a,
    input logic [DW-1:0] opnd_b
);

    logic xa, xb, ma, mb, wr_a;
    assign xa   = exm_we && (exm_rd != '0) && (exm_rd == ex_src_a);
    assign xb   = exm_we && (exm_rd != '0) && (exm_rd == ex_src_b);
    assign ma   = mwb_we && (mwb_rd != '0) && (mwb_rd == ex_src_a);
    assign mb   = mwb_we && (mwb_rd != '0) && (mwb_rd == ex_src_b);
    assign wr_a = mwb_we && (mwb_rd != '0) && (mwb_rd == id_rs_a);

    AST_EXM_FWD_A: assert property (@(posedge clk) disable iff (rst)
        xa |-> (sel_a == 2'b10 && opnd_a == exm_val)); // R1
    AST_EXM_FWD_B: assert property (@(posedge clk) disable iff (rst)
        xb |-> (sel_b == 2'b10 && opnd_b == exm_val)); // R3
    AST_MWB_FWD_A: assert property (@(posedge clk) disable iff (rst)
        (ma && !xa) |-> (sel_a == 2'b01 && opnd_a == mwb_val)); // R2
    AST_MWB_FWD_B: assert property (@(posedge clk) disable iff (rst)
        (mb && !xb) |-> (sel_b == 2'b01 && opnd_b == mwb_val)); // R7
    AST_RF_PASS_A: assert property (@(posedge clk) disable iff (rst)
        (!xa && !ma) |-> (sel_a == 2'b00 && opnd_a == ex_rf_a)); // R4
    AST_SRC0_RF_B: assert property (@(posedge clk) disable iff (rst)
        (ex_src_b == '0) |-> (sel_b == 2'b00 && opnd_b == ex_rf_b)); // R5
    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (sel_a != 2'b11 && sel_b != 2'b11)); // R10
    AST_WT_READ: assert property (@(posedge clk) disable iff (rst)
        wr_a |-> (id_val_a == mwb_val)); // R8
    AST_R0_READ: assert property (@(posedge clk) disable iff (rst)
        (id_rs_a == '0) |-> (id_val_a == '0)); // R9
    AST_WR_STORED: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(mwb_we) && ($past(mwb_rd) != '0)
         && (id_rs_a == $past(mwb_rd)) && !wr_a) |-> (id_val_a == $past(mwb_val))); // R9

endmodule

bind opnd_route opnd_route_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .id_rs_a  (id_rs_a),
    .id_val_a (id_val_a),
    .ex_src_a (ex_src_a),
    .ex_src_b (ex_src_b),
    .ex_rf_a  (ex_rf_a),
    .ex_rf_b  (ex_rf_b),
    .exm_we   (exm_we),
    .exm_rd   (exm_rd),
    .exm_val  (exm_val),
    .mwb_we   (mwb_we),
    .mwb_rd   (mwb_rd),
    .mwb_val  (mwb_val),
    .sel_a    (sel_a),
    .sel_b    (sel_b),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b)
);

// File: tb/test_opnd_route.sv
`timescale 1ns/1ps
module test_opnd_route;

    localparam int DW = 32;
    localparam int AW = 5;
    localparam int NREG = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] id_rs_a = '0, id_rs_b = '0;
    logic [DW-1:0] id_val_a, id_val_b;
    logic [AW-1:0] ex_src_a = '0, ex_src_b = '0;
    logic [DW-1:0] ex_rf_a = '0, ex_rf_b = '0;
    logic          exm_we = 1'b0, mwb_we = 1'b0;
    logic [AW-1:0] exm_rd = '0, mwb_rd = '0;
    logic [DW-1:0] exm_val = '0, mwb_val = '0;
    logic [1:0]    sel_a, sel_b;
    logic [DW-1:0] opnd_a, opnd_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [DW-1:0] mdl [NREG];

    always #2.5 clk = ~clk;

    opnd_route #(.DW(DW), .AW(AW)) i_opnd_route (
        .clk(clk), .rst(rst),
        .id_rs_a(id_rs_a), .id_rs_b(id_rs_b), .id_val_a(id_val_a), .id_val_b(id_val_b),
        .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .ex_rf_a(ex_rf_a), .ex_rf_b(ex_rf_b),
        .exm_we(exm_we), .exm_rd(exm_rd), .exm_val(exm_val),
        .mwb_we(mwb_we), .mwb_rd(mwb_rd), .mwb_val(mwb_val),
        .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    function automatic logic [1:0] exp_sel(input logic [AW-1:0] s);
        if (exm_we && exm_rd != 0 && exm_rd == s) return 2'b10;
        if (mwb_we && mwb_rd != 0 && mwb_rd == s) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [DW-1:0] exp_op(input logic [AW-1:0] s, input logic [DW-1:0] rf);
        logic [1:0] e;
        e = exp_sel(s);
        return (e == 2'b10) ? exm_val : (e == 2'b01) ? mwb_val : rf;
    endfunction

    function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] r);
        if (r == 0) return '0;
        if (mwb_we && mwb_rd == r) return mwb_val;
        return mdl[r];
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " sel_a"},  {30'd0, sel_a}, {30'd0, exp_sel(ex_src_a)});
        chk({tag, " opnd_a"}, opnd_a, exp_op(ex_src_a, ex_rf_a));
        chk({tag, " sel_b"},  {30'd0, sel_b}, {30'd0, exp_sel(ex_src_b)});
        chk({tag, " opnd_b"}, opnd_b, exp_op(ex_src_b, ex_rf_b));
        chk({tag, " id_val_a"}, id_val_a, exp_rd(id_rs_a));
        chk({tag, " id_val_b"}, id_val_b, exp_rd(id_rs_b));
    endtask

    // inputs already set after a negedge; sample, then let the edge commit
    task automatic settle_and_check(input string tag);
        #1;
        check_all(tag);
        if (mwb_we && mwb_rd != 0) mdl[mwb_rd] = mwb_val;
        @(negedge clk);
    endtask

    task automatic drive(input logic [AW-1:0] sa, input logic [AW-1:0] sb,
                         input logic xw, input logic [AW-1:0] xr,
                         input logic ww, input logic [AW-1:0] wr,
                         input logic [AW-1:0] ra, input logic [AW-1:0] rb);
        ex_src_a = sa; ex_src_b = sb;
        exm_we = xw; exm_rd = xr; mwb_we = ww; mwb_rd = wr;
        id_rs_a = ra; id_rs_b = rb;
        ex_rf_a = 32'hA000_0000 | DW'(sa);
        ex_rf_b = 32'hB000_0000 | DW'(sb);
        exm_val = 32'h1111_0000 | DW'(xr);
        mwb_val = 32'h2222_0000 | DW'(wr);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < NREG; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R9: reset state of every register through both read ports
        for (int i = 0; i < NREG; i++) begin
            id_rs_a = AW'(i); id_rs_b = AW'(NREG - 1 - i);
            #1;
            chk("R9 reset read A", id_val_a, '0);
            chk("R9 reset read B", id_val_b, '0);
            @(negedge clk);
        end

        drive(5, 6, 1, 7, 1, 8, 9, 10);   settle_and_check("R4 no dependency");
        drive(3, 6, 1, 3, 0, 0, 1, 2);    settle_and_check("R1 exm to A");
        drive(4, 9, 1, 12, 1, 9, 0, 0);   settle_and_check("R2 R7 mwb to B");
        drive(13, 13, 1, 13, 1, 13, 0, 0); settle_and_check("R3 both match");
        drive(0, 0, 1, 0, 1, 0, 0, 0);    settle_and_check("R5 reg0 target");
        drive(14, 15, 0, 14, 0, 15, 0, 0); settle_and_check("R6 we low");
        drive(2, 21, 1, 2, 1, 21, 0, 0);  settle_and_check("R7 split sources");

        // R8 write and read register 31 in the same cycle, then R9 stored
        drive(0, 0, 0, 0, 1, 31, 31, 31);
        mwb_val = 32'hDEAD_BEEF;
        settle_and_check("R8 write-through r31");
        drive(0, 0, 0, 0, 0, 0, 31, 31);  settle_and_check("R9 stored r31");
        // R9 writes to register 0 are dropped
        drive(0, 0, 0, 0, 1, 0, 0, 0);
        mwb_val = 32'hFFFF_FFFF;
        settle_and_check("R9 r0 write");
        drive(0, 0, 0, 0, 0, 0, 0, 31);   settle_and_check("R9 r0 after write");

        // R10 and all others: random mix, small index range for collisions
        for (int n = 0; n < 3000; n++) begin
            ex_src_a = AW'($urandom_range(0, 3));
            ex_src_b = AW'($urandom_range(0, 3));
            exm_rd   = AW'($urandom_range(0, 3));
            mwb_rd   = AW'($urandom_range(0, 3));
            id_rs_a  = AW'($urandom_range(0, 3));
            id_rs_b  = AW'($urandom_range(0, 3));
            exm_we   = 1'($urandom);
            mwb_we   = 1'($urandom);
            ex_rf_a  = $urandom; ex_rf_b = $urandom;
            exm_val  = $urandom; mwb_val = $urandom;
            settle_and_check("R1-mix random");
            if (sel_a == 2'b11 || sel_b == 2'b11) begin
                n_chk++; n_bad++;
                $display("FAIL R10: actual sel 11 expected legal code");
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule